// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block sits beside the program counter of a short in-order pipeline that fetches, decodes, reads operands and executes. A repeat command loads an iteration count and a pair of loop bounds. The bounds cover either the single instruction that follows the command or a block of instructions between a start address and an end address. Each time the fetch stage presents the end address, the controller supplies the next fetch address itself. While passes remain, that address is the loop start. On the last pass it is the address just past the end. A dedicated down-counter tracks the passes.

The only cost of a loop is one pipeline flush, requested in the cycle after the command is taken. After that the pipeline stays full of loop-body instructions, and no branch ever occupies a slot. Nested loops and interrupts are not handled: while a loop is running, any new repeat command is dropped.

Top module: `zol_ctrl`

## Requirements
- R1: After reset, `next_pc_valid`, `loop_active` and `flush_req` are all low.
- R2: A repeat command taken while idle raises `flush_req` for exactly one cycle, the cycle after the command. Over a whole loop, `flush_req` is never high for more than one cycle.
- R3: While a loop runs and more than one pass remains, fetching the end address drives `next_pc_valid` high with `next_pc` equal to the loop start.
- R4: With `rpt_block` = 0 (single-instruction mode), `rpt_start` is used as both bounds and `rpt_end` is ignored. The same address is fetched again on every pass.
- R5: A count of 0 or 1 runs the body once. A count N > 1 runs it N times, counted as fetches of the end address while the loop runs.
- R6: On the last pass, fetching the end address drives `next_pc` to end + 1 (wrapping at the address width) with `next_pc_valid` high. `loop_active` is low in that same cycle and stays low afterwards.
- R7: While a loop runs, fetching any address other than the end address leaves `next_pc_valid` low.
- R8: A repeat command that arrives while a loop is running has no effect. No flush is raised, and the bounds and the remaining count are unchanged.
- R9: While no loop runs, `next_pc_valid` stays low whatever `fetch_pc` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rpt_valid | input | 1 | Repeat command present this cycle |
| rpt_block | input | 1 | 1 = block mode, 0 = single-instruction mode |
| rpt_count | input | CW | Iteration count (0 is treated as 1) |
| rpt_start | input | AW | First address of the loop body |
| rpt_end | input | AW | Last address of the body (block mode only) |
| fetch_pc | input | AW | Address being fetched this cycle |
| next_pc_valid | output | 1 | Override the sequential next fetch address |
| next_pc | output | AW | Override address |
| loop_active | output | 1 | A loop is running and not exiting this cycle |
| flush_req | output | 1 | One-cycle pipeline flush at loop setup |

## Verification
The loop is driven in single-instruction mode and in block mode, with block lengths of one, two, three, four and five instructions. Counts of 0, 1, 2, 3, 4 and 255 are used. Count 0 against count 1 shows that both give exactly one pass, and a block of length one shows that block mode with equal bounds behaves like single mode. In single mode a different end address is supplied on purpose, to show that it is not used. A repeat command injected partway through a running loop shows whether the loop's pass count and its single flush survive untouched.

// File: rtl/zol_ctrl.sv
module zol_ctrl #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rpt_valid,
  input  logic          rpt_block,
  input  logic [CW-1:0] rpt_count,
  input  logic [AW-1:0] rpt_start,
  input  logic [AW-1:0] rpt_end,
  input  logic [AW-1:0] fetch_pc,
  output logic          next_pc_valid,
  output logic [AW-1:0] next_pc,
  output logic          loop_active,
  output logic          flush_req
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic          busy_q;
  logic          flush_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] end_q;
  logic [CW-1:0] left_q;

  logic accept, at_end, final_pass;

  assign accept     = rpt_valid & ~busy_q;
  assign at_end     = busy_q & (fetch_pc == end_q);
  assign final_pass = (left_q == ONE);

  assign next_pc_valid = at_end;
  assign next_pc       = final_pass ? end_q + AW'(1) : start_q;
  assign loop_active   = busy_q & ~(at_end & final_pass);
  assign flush_req     = flush_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      flush_q <= 1'b0;
      start_q <= '0;
      end_q   <= '0;
      left_q  <= '0;
    end else begin
      flush_q <= accept;
      if (accept) begin
        busy_q  <= 1'b1;
        start_q <= rpt_start;
        end_q   <= rpt_block ? rpt_end : rpt_start;
        left_q  <= (rpt_count == '0) ? ONE : rpt_count;
      end else if (at_end) begin
        if (final_pass) busy_q <= 1'b0;
        else            left_q <= left_q - ONE;
      end
    end
  end

endmodule

// File: rtl/zol_ctrl_chk.sv
module zol_ctrl_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rpt_valid,
  input logic [AW-1:0] fetch_pc,
  input logic          next_pc_valid,
  input logic [AW-1:0] next_pc,
  input logic          loop_active,
  input logic          flush_req,
  input logic          busy_q,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] end_q
);

  AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) flush_req |=> !flush_req); // R2
  AST_FLUSH_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n) flush_req |-> $past(rpt_valid)); // R2
  AST_LOOP_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (next_pc_valid && loop_active) |-> next_pc == start_q); // R3
  AST_EXIT_TARGET: assert property (@(posedge clk) disable iff (!rst_n) (next_pc_valid && !loop_active) |-> next_pc == end_q + AW'(1)); // R6
  AST_EXIT_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (next_pc_valid && !loop_active) |=> !busy_q); // R6
  AST_OVR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) next_pc_valid |-> (busy_q && fetch_pc == end_q)); // R7
  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rst_n) (busy_q && rpt_valid) |=> ($stable(start_q) && $stable(end_q) && !flush_req)); // R8
  AST_IDLE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n) !busy_q |-> !next_pc_valid); // R9

endmodule

bind zol_ctrl zol_ctrl_chk #(.AW(AW)) i_zol_ctrl_chk (
  .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .fetch_pc(fetch_pc),
  .next_pc_valid(next_pc_valid), .next_pc(next_pc), .loop_active(loop_active),
  .flush_req(flush_req), .busy_q(busy_q), .start_q(start_q), .end_q(end_q)
);

// File: tb/test_zol_ctrl.sv
module test_zol_ctrl;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rpt_valid = 1'b0, rpt_block = 1'b0;
  logic [CW-1:0] rpt_count = '0;
  logic [AW-1:0] rpt_start = '0, rpt_end = '0, fetch_pc = '0;
  logic next_pc_valid, loop_active, flush_req;
  logic [AW-1:0] next_pc;

  int n_cmp = 0, n_bad = 0;
  int m_busy = 0, m_rem = 0, m_start = 0, m_end = 0, m_flush = 0;
  int pc = 'h100;
  int passes = 0, flushes = 0;

  always #(PERIOD/2) clk = ~clk;

  zol_ctrl #(.AW(AW), .CW(CW)) i_zol_ctrl (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_block(rpt_block),
    .rpt_count(rpt_count), .rpt_start(rpt_start), .rpt_end(rpt_end),
    .fetch_pc(fetch_pc), .next_pc_valid(next_pc_valid), .next_pc(next_pc),
    .loop_active(loop_active), .flush_req(flush_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (pc %0h)", req, act, exp, pc);
    end
  endtask

  task automatic step(input bit rv, input bit blk, input int cnt, input int s, input int e);
    bit hit, last;
    int e_pc;
    @(negedge clk);
    rpt_valid = rv; rpt_block = blk; rpt_count = cnt[CW-1:0];
    rpt_start = s[AW-1:0]; rpt_end = e[AW-1:0]; fetch_pc = pc[AW-1:0];
    #1;
    hit  = (m_busy != 0) && (pc == m_end);
    last = (m_rem == 1);
    e_pc = last ? (m_end + 1) % (1 << AW) : m_start;
    check(m_busy != 0 ? "R7 override" : "R9 idle override", int'(next_pc_valid), int'(hit));
    if (hit) check(last ? "R6 exit address" : "R3 loop-back address", int'(next_pc), e_pc);
    check("R6 loop_active", int'(loop_active), int'((m_busy != 0) && !(hit && last)));
    check("R2 flush_req", int'(flush_req), m_flush);
    if (hit) passes++;
    if (flush_req) flushes++;
    m_flush = (rv && m_busy == 0) ? 1 : 0;
    if (rv && m_busy == 0) begin
      m_busy = 1; m_start = s; m_end = blk ? e : s; m_rem = (cnt == 0) ? 1 : cnt;
    end else if (hit) begin
      if (last) m_busy = 0; else m_rem--;
    end
    pc = hit ? e_pc : (pc + 1) % (1 << AW);
  endtask

  task automatic run_loop(input bit blk, input int cnt, input int len, input bit poke);
    int s, e, guard;
    s = pc + 1;
    e = blk ? s + len - 1 : s + 9;  // single mode: deliberately wrong end (R4)
    passes = 0; flushes = 0;
    step(1'b1, blk, cnt, s, e);
    guard = 0;
    while (m_busy != 0 && guard < 3000) begin
      step(poke && guard == 2, 1'b1, 7, pc + 40, pc + 50);
      guard++;
    end
    step(1'b0, 1'b0, 0, 0, 0);
    step(1'b0, 1'b0, 0, 0, 0);
    check(blk ? "R5 pass count" : "R4 R5 single-mode pass count", passes, (cnt == 0) ? 1 : cnt);
    check(poke ? "R8 flushes with ignored command" : "R2 flushes per loop", flushes, 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset next_pc_valid", int'(next_pc_valid), 0);
    check("R1 reset loop_active", int'(loop_active), 0);
    check("R1 reset flush_req", int'(flush_req), 0);
    rst_n = 1'b1;
    repeat (3) step(1'b0, 1'b0, 0, 0, 0);
    run_loop(1'b0, 3, 1, 1'b0);
    run_loop(1'b0, 0, 1, 1'b0);
    run_loop(1'b0, 1, 1, 1'b0);
    run_loop(1'b1, 4, 4, 1'b0);
    run_loop(1'b1, 0, 3, 1'b0);
    run_loop(1'b1, 1, 2, 1'b0);
    run_loop(1'b1, 2, 1, 1'b0);
    run_loop(1'b1, 3, 5, 1'b1);
    run_loop(1'b0, 4, 1, 1'b1);
    run_loop(1'b1, 255, 2, 1'b0);
    pc = 'hFFFC;
    run_loop(1'b1, 2, 3, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule